// File: doc/BRIEF.md
# MBLT Burst Slave

This block is the slave side of a VME multiplexed 64-bit block transfer. It watches the address strobe, the two data strobes, the write line, LWORD, the six-bit address modifier, and the address and data lines. When an address phase carries an enabled 64-bit block-transfer modifier, an aligned address and a matching base, it accepts the burst. It moves one 64-bit word per data beat between the bus and a local synchronous memory, and it answers each beat with a DTACK handshake.

The burst opens with a handshake that carries only the address and moves no data. In every later beat, the address lines A31..A1, the LWORD line and the 32 data lines together form one 64-bit word. The local word index starts at the word selected by the start address and steps by one after each completed beat. The burst lasts until the master releases the address strobe.

All bus inputs are resynchronised to `clk` through a parameterised number of register stages, so every latency below counts from the synchronised view.

Top module: `mblt_slave`

## Requirements
- R1: After reset, `bus_dtack_n` is 1, `bus_drive_oe` is 0 and `mem_we` is 0.
- R2: An address phase (strobe low, both data strobes low) with a hit is answered by driving `bus_dtack_n` low. No memory write and no bus drive occur in that phase, and DTACK is released after both data strobes go high.
- R3: A hit needs (A & `cfg_mask`) == (`cfg_base` & `cfg_mask`). Here A is the byte address {A31..A1,0} for the 32-bit modifiers, and the same address with bits 31:24 forced to zero for the 24-bit modifiers. On a mismatch the whole cycle is ignored: DTACK stays released, there is no drive and no write.
- R4: The accepted modifiers and their enable bits are 0x08 → `cfg_am_en[0]`, 0x0C → `cfg_am_en[1]`, 0x38 → `cfg_am_en[2]` and 0x3C → `cfg_am_en[3]`. 0x08 and 0x0C use 32-bit decoding, 0x38 and 0x3C use 24-bit decoding. Any other code, a cleared enable bit, or `cfg_enable`=0 makes the slave ignore the cycle.
- R5: An address phase with A2 or A1 set (start not 8-byte aligned), or with LWORD high, is ignored.
- R6: On a write beat the slave writes the word {A31..A1, LWORD, D31..D0} (bits 63:33, bit 32, bits 31:0) to memory with one `mem_we` pulse, and only then asserts DTACK.
- R7: On a read beat the slave drives the addressed word in the same packing, with `bus_drive_oe` high before DTACK falls. `bus_drive_oe` goes low one synchronised cycle after both data strobes are high.
- R8: The word index starts at byte-address bits [MEM_AW+2:3] of the start address, advances by one after each completed beat, and wraps modulo 2^MEM_AW.
- R9: Releasing the address strobe ends the burst. One synchronised cycle later DTACK is high and the drivers are off, even in the middle of a beat.
- R10: Within a beat, DTACK is released one synchronised cycle after both data strobes are high, and the next beat is accepted only after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_as_n | input | 1 | Address strobe, active low |
| bus_ds_n | input | 2 | Data strobes, active low |
| bus_write_n | input | 1 | Low for write bursts |
| bus_lword_n_i | input | 1 | LWORD line in (bit 32 in data beats) |
| bus_am | input | 6 | Address modifier |
| bus_addr_i | input | 31 | Address lines A31..A1 in (bits 63:33 in data beats) |
| bus_data_i | input | 32 | Data lines in |
| bus_dtack_n | output | 1 | Data acknowledge, active low |
| bus_addr_o | output | 31 | Address lines driven on read beats |
| bus_lword_n_o | output | 1 | LWORD driven on read beats |
| bus_data_o | output | 32 | Data lines driven on read beats |
| bus_drive_oe | output | 1 | Enables the address/LWORD/data drivers |
| cfg_enable | input | 1 | Slave enable |
| cfg_am_en | input | 4 | Per-modifier enable bits (see R4) |
| cfg_base | input | 32 | Base compare value |
| cfg_mask | input | 32 | Compare mask |
| mem_addr | output | MEM_AW | Local memory word index |
| mem_we | output | 1 | Local memory write enable |
| mem_wdata | output | 64 | Local memory write word |
| mem_rdata | input | 64 | Local memory read word, one cycle after `mem_addr` |

## Verification
A corrupted word pointer shows up in the first beat after it goes wrong. It appears as a wrong word in the local memory after a write, or as a wrong word on the bus at DTACK of a read, and the wrap test at the top index exposes an off-by-one carry. A wrong handshake state shows as DTACK that never falls, which the polling tasks flag within 50 cycles, or as DTACK that stays low after the strobes release, which is flagged one beat later. A decoder that accepts too much shows as any DTACK edge, `mem_we` pulse or driver enable during the 24-cycle watch window of an ignored cycle.

// File: rtl/mblt_pkg.sv
package mblt_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR_ACK,
      ST_IGNORE,
      ST_BEAT,
      ST_RD_WAIT,
      ST_RD_DRIVE,
      ST_ACK
   } mblt_state_e;

   localparam logic [5:0] AM_A32_BLK64_D = 6'h08;
   localparam logic [5:0] AM_A32_BLK64_P = 6'h0C;
   localparam logic [5:0] AM_A24_BLK64_D = 6'h38;
   localparam logic [5:0] AM_A24_BLK64_P = 6'h3C;

   // one-hot slot of a 64-bit block modifier, zero for any other code
   function automatic logic [3:0] am_slot(input logic [5:0] am);
      logic [3:0] s;
      s = 4'b0000;
      case (am)
         AM_A32_BLK64_D: s = 4'b0001;
         AM_A32_BLK64_P: s = 4'b0010;
         AM_A24_BLK64_D: s = 4'b0100;
         AM_A24_BLK64_P: s = 4'b1000;
         default:        s = 4'b0000;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/mblt_sync.sv
module mblt_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] pipe [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int k = 0; k < STAGES; k++) pipe[k] <= '1;
            end else begin
               pipe[0] <= d;
               for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
            end
         end
         assign q = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/mblt_decode.sv
module mblt_decode
   import mblt_pkg::*;
#(
   parameter int MEM_AW = 6
) (
   input  logic [5:0]        am,
   input  logic [31:1]       addr,
   input  logic              lword_n,
   input  logic              cfg_enable,
   input  logic [3:0]        cfg_am_en,
   input  logic [31:0]       cfg_base,
   input  logic [31:0]       cfg_mask,
   output logic              hit,
   output logic [MEM_AW-1:0] start_word
);
   logic [31:0] byte_addr;
   logic [31:0] eff_addr;
   logic [3:0]  slot;
   logic        is_a24;
   logic        am_ok;
   logic        base_ok;
   logic        aligned;

   always_comb begin
      byte_addr = {addr, 1'b0};
      slot      = am_slot(am);
      is_a24    = slot[2] | slot[3];
      eff_addr  = is_a24 ? {8'h00, byte_addr[23:0]} : byte_addr;
      am_ok     = |(slot & cfg_am_en);
      base_ok   = (eff_addr & cfg_mask) == (cfg_base & cfg_mask);
      aligned   = (byte_addr[2:1] == 2'b00) && !lword_n;
      hit       = cfg_enable && am_ok && base_ok && aligned;
   end

   assign start_word = eff_addr[MEM_AW+2:3];
endmodule

// File: rtl/mblt_fsm.sv
module mblt_fsm
   import mblt_pkg::*;
#(
   parameter int MEM_AW = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              as_n,
   input  logic [1:0]        ds_n,
   input  logic              write_n,
   input  logic              lword_n,
   input  logic [31:1]       addr,
   input  logic [31:0]       data,
   input  logic              hit,
   input  logic [MEM_AW-1:0] start_word,
   output logic              dtack_n,
   output logic              drive_oe,
   output logic [63:0]       drive_word,
   output logic [MEM_AW-1:0] mem_addr,
   output logic              mem_we,
   output logic [63:0]       mem_wdata,
   input  logic [63:0]       mem_rdata
);
   mblt_state_e       state;
   logic [MEM_AW-1:0] ptr;
   logic              is_wr;
   logic              ds_low;
   logic              ds_high;

   assign ds_low  = (ds_n == 2'b00);
   assign ds_high = (ds_n == 2'b11);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         dtack_n    <= 1'b1;
         drive_oe   <= 1'b0;
         drive_word <= '0;
         ptr        <= '0;
         is_wr      <= 1'b0;
      end else if (state != ST_IDLE && as_n) begin
         state    <= ST_IDLE;
         dtack_n  <= 1'b1;
         drive_oe <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (!as_n && ds_low) begin
                  if (hit) begin
                     ptr     <= start_word;
                     is_wr   <= !write_n;
                     dtack_n <= 1'b0;
                     state   <= ST_ADDR_ACK;
                  end else begin
                     state <= ST_IGNORE;
                  end
               end
            end
            ST_IGNORE: state <= ST_IGNORE;
            ST_ADDR_ACK: begin
               if (ds_high) begin
                  dtack_n <= 1'b1;
                  state   <= ST_BEAT;
               end
            end
            ST_BEAT: begin
               if (ds_low) begin
                  if (is_wr) begin
                     dtack_n <= 1'b0;
                     state   <= ST_ACK;
                  end else begin
                     state <= ST_RD_WAIT;
                  end
               end
            end
            ST_RD_WAIT: begin
               if (!ds_low) begin
                  state <= ST_BEAT;
               end else begin
                  drive_word <= mem_rdata;
                  drive_oe   <= 1'b1;
                  state      <= ST_RD_DRIVE;
               end
            end
            ST_RD_DRIVE: begin
               if (!ds_low) begin
                  drive_oe <= 1'b0;
                  state    <= ST_BEAT;
               end else begin
                  dtack_n <= 1'b0;
                  state   <= ST_ACK;
               end
            end
            ST_ACK: begin
               if (ds_high) begin
                  dtack_n  <= 1'b1;
                  drive_oe <= 1'b0;
                  ptr      <= ptr + MEM_AW'(1);
                  state    <= ST_BEAT;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign mem_addr  = ptr;
   assign mem_we    = (state == ST_BEAT) && ds_low && is_wr && !as_n;
   assign mem_wdata = {addr, lword_n, data};

   // R9: strobe release ends the burst within one cycle
   a_r9_as_release: assert property (@(posedge clk) disable iff (!rst_n)
      as_n |=> (dtack_n && !drive_oe));
   // R7: drivers off after both data strobes are high
   a_r7_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
      ds_high |=> !drive_oe);
   // R7: drivers only on read bursts
   a_r7_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
      drive_oe |-> write_n);
   // R7: a read acknowledge comes with data already driven
   a_r7_data_before_ack: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(dtack_n) && !is_wr && state == ST_ACK) |-> drive_oe);
   // R6: the write happens before the acknowledge
   a_r6_we_before_ack: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> dtack_n);
   // R10: acknowledge released once the strobes are released
   a_r10_dtack_release: assert property (@(posedge clk) disable iff (!rst_n)
      (!dtack_n && ds_high) |=> dtack_n);
   // R3: an ignored cycle stays silent
   a_r3_ignore_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IGNORE) |-> (dtack_n && !drive_oe && !mem_we));
   // R2: address phase never writes
   a_r2_addr_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ADDR_ACK) |-> (!mem_we && !drive_oe));
endmodule

// File: rtl/mblt_slave.sv
module mblt_slave
   import mblt_pkg::*;
#(
   parameter int MEM_AW      = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_as_n,
   input  logic [1:0]        bus_ds_n,
   input  logic              bus_write_n,
   input  logic              bus_lword_n_i,
   input  logic [5:0]        bus_am,
   input  logic [31:1]       bus_addr_i,
   input  logic [31:0]       bus_data_i,
   output logic              bus_dtack_n,
   output logic [31:1]       bus_addr_o,
   output logic              bus_lword_n_o,
   output logic [31:0]       bus_data_o,
   output logic              bus_drive_oe,
   input  logic              cfg_enable,
   input  logic [3:0]        cfg_am_en,
   input  logic [31:0]       cfg_base,
   input  logic [31:0]       cfg_mask,
   output logic [MEM_AW-1:0] mem_addr,
   output logic              mem_we,
   output logic [63:0]       mem_wdata,
   input  logic [63:0]       mem_rdata
);
   localparam int SYNC_W = 1 + 2 + 1 + 1 + 6 + 31 + 32;

   generate
      if (MEM_AW < 1 || MEM_AW > 29) begin : g_bad_aw
         $error("mblt_slave: MEM_AW must lie in 1..29");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("mblt_slave: SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic [SYNC_W-1:0] raw_bus;
   logic [SYNC_W-1:0] syn_bus;
   logic              s_as_n;
   logic [1:0]        s_ds_n;
   logic              s_write_n;
   logic              s_lword_n;
   logic [5:0]        s_am;
   logic [31:1]       s_addr;
   logic [31:0]       s_data;
   logic              hit;
   logic [MEM_AW-1:0] start_word;
   logic [63:0]       drive_word;

   assign raw_bus = {bus_as_n, bus_ds_n, bus_write_n, bus_lword_n_i,
                     bus_am, bus_addr_i, bus_data_i};
   assign {s_as_n, s_ds_n, s_write_n, s_lword_n, s_am, s_addr, s_data} = syn_bus;

   mblt_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(syn_bus));

   mblt_decode #(.MEM_AW(MEM_AW)) decode_i (
      .am(s_am), .addr(s_addr), .lword_n(s_lword_n),
      .cfg_enable(cfg_enable), .cfg_am_en(cfg_am_en),
      .cfg_base(cfg_base), .cfg_mask(cfg_mask),
      .hit(hit), .start_word(start_word));

   mblt_fsm #(.MEM_AW(MEM_AW)) fsm_i (
      .clk(clk), .rst_n(rst_n), .as_n(s_as_n), .ds_n(s_ds_n),
      .write_n(s_write_n), .lword_n(s_lword_n), .addr(s_addr),
      .data(s_data), .hit(hit), .start_word(start_word),
      .dtack_n(bus_dtack_n), .drive_oe(bus_drive_oe),
      .drive_word(drive_word), .mem_addr(mem_addr), .mem_we(mem_we),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

   assign bus_addr_o    = drive_word[63:33];
   assign bus_lword_n_o = drive_word[32];
   assign bus_data_o    = drive_word[31:0];
endmodule

// File: tb/mblt_slave_tb_top.sv
module mblt_slave_tb_top;
   localparam int MEM_AW = 6;
   localparam int DEPTH  = 1 << MEM_AW;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_as_n = 1'b1;
   logic [1:0]        bus_ds_n = 2'b11;
   logic              bus_write_n = 1'b1;
   logic              bus_lword_n_i = 1'b1;
   logic [5:0]        bus_am = 6'h00;
   logic [31:1]       bus_addr_i = '0;
   logic [31:0]       bus_data_i = '0;
   logic              bus_dtack_n;
   logic [31:1]       bus_addr_o;
   logic              bus_lword_n_o;
   logic [31:0]       bus_data_o;
   logic              bus_drive_oe;
   logic              cfg_enable = 1'b0;
   logic [3:0]        cfg_am_en = 4'b0000;
   logic [31:0]       cfg_base = '0;
   logic [31:0]       cfg_mask = '0;
   logic [MEM_AW-1:0] mem_addr;
   logic              mem_we;
   logic [63:0]       mem_wdata;
   logic [63:0]       mem_rdata;

   int checks = 0;
   int errors = 0;
   int ack_cnt = 0;
   int we_cnt = 0;
   int oe_cnt = 0;
   logic prev_dtack = 1'b1;
   logic [63:0] mem [DEPTH];
   logic [63:0] exp_q [$];

   always #4 clk = ~clk;

   mblt_slave #(.MEM_AW(MEM_AW), .SYNC_STAGES(2)) dut_i (.*);

   // local memory model, one cycle read latency
   always @(posedge clk) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
   end

   task automatic chk(input bit ok, input string req,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // scoreboard monitor: compares each read acknowledge with the queue
   always @(negedge clk) begin
      if (mem_we) we_cnt++;
      if (bus_drive_oe) oe_cnt++;
      if (prev_dtack && !bus_dtack_n) begin
         ack_cnt++;
         if (bus_drive_oe) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R7 unexpected read beat",
                   {bus_addr_o, bus_lword_n_o, bus_data_o}, 64'h0);
            end else begin
               logic [63:0] e;
               e = exp_q.pop_front();
               chk({bus_addr_o, bus_lword_n_o, bus_data_o} == e, "R7 read word",
                   {bus_addr_o, bus_lword_n_o, bus_data_o}, e);
            end
         end
      end
      prev_dtack = bus_dtack_n;
   end

   task automatic wait_dtack(input logic val, input string req);
      int n;
      n = 0;
      while (bus_dtack_n !== val && n < 50) begin
         @(negedge clk);
         n++;
      end
      chk(bus_dtack_n === val, req, 64'(bus_dtack_n), 64'(val));
   endtask

   task automatic addr_phase(input logic [31:0] a, input logic [5:0] am,
                             input logic wr, input logic lw);
      @(negedge clk);
      bus_am = am; bus_addr_i = a[31:1]; bus_lword_n_i = lw; bus_write_n = !wr;
      @(negedge clk);
      bus_as_n = 1'b0;
      @(negedge clk);
      bus_ds_n = 2'b00;
   endtask

   task automatic end_burst();
      @(negedge clk);
      bus_as_n = 1'b1; bus_ds_n = 2'b11; bus_write_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(bus_dtack_n && !bus_drive_oe, "R9 idle after strobe release",
          {bus_dtack_n, bus_drive_oe}, 64'h2);
   endtask

   task automatic open_burst(input logic [31:0] a, input logic [5:0] am,
                             input logic wr);
      int w0;
      addr_phase(a, am, wr, 1'b0);
      w0 = we_cnt;
      wait_dtack(1'b0, "R2 address phase ack");
      chk(we_cnt == w0 && !bus_drive_oe, "R2 no data in address phase",
          64'(we_cnt - w0), 64'h0);
      bus_ds_n = 2'b11;
      wait_dtack(1'b1, "R10 dtack release after address phase");
   endtask

   task automatic write_beat(input logic [63:0] w);
      @(negedge clk);
      bus_addr_i = w[63:33]; bus_lword_n_i = w[32]; bus_data_i = w[31:0];
      @(negedge clk);
      bus_ds_n = 2'b00;
      wait_dtack(1'b0, "R6 write beat ack");
      bus_ds_n = 2'b11;
      wait_dtack(1'b1, "R10 write beat release");
   endtask

   task automatic read_beat(input logic [63:0] e);
      exp_q.push_back(e);
      @(negedge clk);
      bus_ds_n = 2'b00;
      wait_dtack(1'b0, "R7 read beat ack");
      bus_ds_n = 2'b11;
      wait_dtack(1'b1, "R10 read beat release");
      chk(!bus_drive_oe, "R7 drivers off after beat", 64'(bus_drive_oe), 64'h0);
   endtask

   task automatic ignored_cycle(input logic [31:0] a, input logic [5:0] am,
                                input logic lw, input string req);
      int a0, w0, o0;
      a0 = ack_cnt; w0 = we_cnt; o0 = oe_cnt;
      addr_phase(a, am, 1'b1, lw);
      repeat (24) @(negedge clk);
      chk(ack_cnt == a0 && we_cnt == w0 && oe_cnt == o0 && bus_dtack_n, req,
          64'(ack_cnt - a0 + we_cnt - w0 + oe_cnt - o0), 64'h0);
      end_burst();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [63:0] wv [4];
      for (int i = 0; i < DEPTH; i++) mem[i] = {32'hC0DE0000 + i, 32'h5A5A0000 ^ i};
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(bus_dtack_n && !bus_drive_oe && !mem_we, "R1 reset outputs",
          {bus_dtack_n, bus_drive_oe, mem_we}, 64'h4);
      rst_n = 1'b1;
      cfg_enable = 1'b1; cfg_am_en = 4'b1111;
      cfg_base = 32'h6400_0000; cfg_mask = 32'hFF00_0000;

      // R6 R8: 4-word write burst at index 32 with modifier 0x08
      wv[0] = 64'h0011_2233_4455_6677; wv[1] = 64'h8899_AABB_CCDD_EEFF;
      wv[2] = 64'h0123_4567_89AB_CDEF; wv[3] = 64'hFEDC_BA98_7654_3210;
      open_burst(32'h6400_0100, 6'h08, 1'b1);
      for (int i = 0; i < 4; i++) write_beat(wv[i]);
      end_burst();
      for (int i = 0; i < 4; i++)
         chk(mem[32+i] == wv[i], "R6 R8 written word", mem[32+i], wv[i]);

      // R7 R8: read the same words back with modifier 0x0C
      open_burst(32'h6400_0100, 6'h0C, 1'b0);
      for (int i = 0; i < 4; i++) read_beat(wv[i]);
      end_burst();
      chk(exp_q.size() == 0, "R7 scoreboard drained", 64'(exp_q.size()), 64'h0);

      // R8: wrap from the top index to zero
      open_burst(32'h6400_01F8, 6'h08, 1'b1);
      write_beat(64'hAAAA_0000_0000_0063);
      write_beat(64'hBBBB_0000_0000_0000);
      end_burst();
      chk(mem[63] == 64'hAAAA_0000_0000_0063, "R8 top index", mem[63], 64'hAAAA_0000_0000_0063);
      chk(mem[0] == 64'hBBBB_0000_0000_0000, "R8 wrap to zero", mem[0], 64'hBBBB_0000_0000_0000);

      // R3 R4: 24-bit decoding ignores bits 31:24, modifiers 0x38 and 0x3C
      cfg_base = 32'h0008_0000; cfg_mask = 32'h00F8_0000;
      open_burst(32'hAB08_0040, 6'h38, 1'b1);
      write_beat(64'h2424_2424_0000_0008);
      end_burst();
      chk(mem[8] == 64'h2424_2424_0000_0008, "R3 A24 write", mem[8], 64'h2424_2424_0000_0008);
      open_burst(32'h0008_0040, 6'h3C, 1'b0);
      read_beat(64'h2424_2424_0000_0008);
      read_beat(mem[9]);
      end_burst();

      // R3: base mismatch
      cfg_base = 32'h6400_0000; cfg_mask = 32'hFF00_0000;
      ignored_cycle(32'h6500_0100, 6'h08, 1'b0, "R3 base mismatch ignored");
      // R4: non-block modifier, disabled slot, slave disabled
      ignored_cycle(32'h6400_0100, 6'h09, 1'b0, "R4 modifier 0x09 ignored");
      cfg_am_en = 4'b1110;
      ignored_cycle(32'h6400_0100, 6'h08, 1'b0, "R4 disabled slot ignored");
      cfg_am_en = 4'b1111; cfg_enable = 1'b0;
      ignored_cycle(32'h6400_0100, 6'h0C, 1'b0, "R4 slave disabled ignored");
      cfg_enable = 1'b1;
      // R5: misaligned start and LWORD high
      ignored_cycle(32'h6400_0104, 6'h08, 1'b0, "R5 misaligned ignored");
      ignored_cycle(32'h6400_0100, 6'h08, 1'b1, "R5 LWORD high ignored");

      // R9: strobe released while the address phase is acknowledged
      addr_phase(32'h6400_0100, 6'h08, 1'b0, 1'b0);
      wait_dtack(1'b0, "R2 ack before abort");
      bus_as_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(bus_dtack_n, "R9 abort releases dtack", 64'(bus_dtack_n), 64'h1);
      bus_ds_n = 2'b11;
      end_burst();
      chk(mem[32] == wv[0], "R9 memory untouched after abort", mem[32], wv[0]);

      repeat (4) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule